// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar as packed BCD registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year, with a century flag whose toggling is gated by an enable flag. A prescaler turns the block clock into a one-second tick. In the intended use the clock is a 32.768 kHz time base, so the prescaler divides by 32768. Each tick advances the seconds. Carries then ripple through the whole chain, including month lengths and leap-year February.

A bus front end sets the fields through one shared data byte and seven load strobes, one for each field. Bit 7 of the seconds register is a halt flag: while it is set, the prescaler and every counter hold still. Any load of the seconds register clears the prescaler, so the first tick after a load comes one full period later. Leap years are judged on the two-digit year alone: a value divisible by four is a leap year, and 00 counts as one.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read seconds 00 with halt clear, minutes 00, hours 00 with the century enable and century flag both 0, weekday 1, day 01, month 01 and year 00.
- R2: While running, the seconds register advances by one BCD step once every DIV_COUNT clock cycles (for example 08 to 09 to 10).
- R3: Seconds roll from 59 to 00 and carry into the minutes. Minutes roll from 59 to 00 and carry into the hours. Hours roll from 23 to 00 and carry into the day.
- R4: The weekday field sits in bits 2:0 and counts 1 through 7. At midnight it goes from 7 back to 1.
- R5: After the last day of the month, the day returns to 01 and the month advances. Months 04, 06, 09 and 11 end on day 30. Months 01, 03, 05, 07, 08, 10 and 12 end on day 31. Month 12 rolls to 01 and advances the year.
- R6: In month 02 the last day is 29 when the BCD year is divisible by four (00 included) and 28 otherwise.
- R7: In the hours register, bit 7 is the century enable and bit 6 is the century flag. When the year rolls from 99 to 00, the flag inverts if the enable is 1 and keeps its value if the enable is 0.
- R8: While seconds bit 7 (halt) is 1, no register changes unless it is loaded. Loading the seconds with bit 7 clear resumes counting.
- R9: Loading the seconds clears the prescaler. After the load, the register holds its loaded value for DIV_COUNT-1 cycles and changes on the DIV_COUNT-th.
- R10: A load strobe replaces its field with the data byte on the next edge. Seconds keeps bits 7:0, hours keeps 7:0, year keeps 7:0, minutes keeps 6:0, day keeps 5:0, month keeps 4:0 and weekday keeps 2:0. Unused output bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_sec | input | 1 | Load strobe for seconds and the halt flag |
| ld_min | input | 1 | Load strobe for minutes |
| ld_hour | input | 1 | Load strobe for hours, century enable and century flag |
| ld_wday | input | 1 | Load strobe for the weekday |
| ld_mday | input | 1 | Load strobe for the day of month |
| ld_month | input | 1 | Load strobe for the month |
| ld_year | input | 1 | Load strobe for the year |
| ld_data | input | 8 | Shared load data |
| sec_q | output | 8 | Halt flag in bit 7, BCD seconds in bits 6:0 |
| min_q | output | 8 | BCD minutes |
| hour_q | output | 8 | Century enable, century flag, BCD hours |
| wday_q | output | 8 | Weekday 1 to 7 |
| mday_q | output | 8 | BCD day of month |
| month_q | output | 8 | BCD month |
| year_q | output | 8 | BCD two-digit year |

## Verification
Four kinds of behaviour are checked by properties on every cycle: a seconds load lands exactly as written, a halted clock stays frozen, minutes always follow a seconds wrap, and the century flag holds still whenever its enable is clear. A fifth property checks that a nonzero weekday never drops to zero. The month-length table, the leap-year rule, the century toggle with the enable set, and the exact timing of the tick after a seconds load are shown only by the bench's directed scenarios. In each scenario the calendar is parked just before a boundary and the bench compares full register snapshots against hand-derived values.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int DIV_COUNT = 32768,
  localparam int DW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_sec,
  input  logic       ld_min,
  input  logic       ld_hour,
  input  logic       ld_wday,
  input  logic       ld_mday,
  input  logic       ld_month,
  input  logic       ld_year,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] wday_q,
  output logic [7:0] mday_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);

  logic [DW-1:0] div_q;
  logic          halt_r;
  logic [6:0]    sec_r, min_r;
  logic          cen_en_r, cen_r;
  logic [5:0]    hr_r, mday_r;
  logic [2:0]    wday_r;
  logic [4:0]    mon_r;
  logic [7:0]    yr_r;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic       tick, sec_wrap, min_wrap, day_wrap, mon_wrap, yr_step;
  logic [1:0] leap_sum;
  logic       leap;
  logic [5:0] last_day;

  assign tick     = !halt_r && (div_q == DW'(DIV_COUNT - 1));
  assign sec_wrap = tick && (sec_r == 7'h59);
  assign min_wrap = sec_wrap && (min_r == 7'h59);
  assign day_wrap = min_wrap && (hr_r == 6'h23);
  assign leap_sum = {yr_r[4], 1'b0} + yr_r[1:0];
  assign leap     = (leap_sum == 2'd0);
  assign mon_wrap = day_wrap && (mday_r == last_day);
  assign yr_step  = mon_wrap && (mon_r == 5'h12);

  always_comb begin
    case (mon_r)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      halt_r   <= 1'b0;
      sec_r    <= 7'h00;
      min_r    <= 7'h00;
      cen_en_r <= 1'b0;
      cen_r    <= 1'b0;
      hr_r     <= 6'h00;
      wday_r   <= 3'd1;
      mday_r   <= 6'h01;
      mon_r    <= 5'h01;
      yr_r     <= 8'h00;
    end else begin
      if (ld_sec || halt_r || tick) div_q <= '0;
      else                          div_q <= div_q + DW'(1);

      if (ld_sec) {halt_r, sec_r} <= ld_data;
      else if (tick) sec_r <= sec_wrap ? 7'h00 : 7'(bcd_inc({1'b0, sec_r}));

      if (ld_min) min_r <= ld_data[6:0];
      else if (sec_wrap) min_r <= min_wrap ? 7'h00 : 7'(bcd_inc({1'b0, min_r}));

      if (ld_hour) {cen_en_r, cen_r, hr_r} <= ld_data;
      else begin
        if (min_wrap) hr_r <= day_wrap ? 6'h00 : 6'(bcd_inc({2'b0, hr_r}));
        if (yr_step && yr_r == 8'h99 && cen_en_r) cen_r <= ~cen_r;
      end

      if (ld_wday) wday_r <= ld_data[2:0];
      else if (day_wrap) wday_r <= (wday_r == 3'd7) ? 3'd1 : wday_r + 3'd1;

      if (ld_mday) mday_r <= ld_data[5:0];
      else if (day_wrap) mday_r <= mon_wrap ? 6'h01 : 6'(bcd_inc({2'b0, mday_r}));

      if (ld_month) mon_r <= ld_data[4:0];
      else if (mon_wrap) mon_r <= yr_step ? 5'h01 : 5'(bcd_inc({3'b0, mon_r}));

      if (ld_year) yr_r <= ld_data;
      else if (yr_step) yr_r <= (yr_r == 8'h99) ? 8'h00 : bcd_inc(yr_r);
    end
  end

  assign sec_q   = {halt_r, sec_r};
  assign min_q   = {1'b0, min_r};
  assign hour_q  = {cen_en_r, cen_r, hr_r};
  assign wday_q  = {5'b0, wday_r};
  assign mday_q  = {2'b0, mday_r};
  assign month_q = {3'b0, mon_r};
  assign year_q  = yr_r;

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_sec,
  input logic       ld_min,
  input logic       ld_hour,
  input logic       ld_wday,
  input logic       ld_mday,
  input logic       ld_month,
  input logic       ld_year,
  input logic [7:0] ld_data,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] wday_q,
  input logic [7:0] mday_q,
  input logic [7:0] month_q,
  input logic [7:0] year_q
);

  logic wr_any;
  assign wr_any = ld_sec | ld_min | ld_hour | ld_wday | ld_mday | ld_month | ld_year;

  a_r10_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sec |=> (sec_q == $past(ld_data)));

  a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && !wr_any) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                               $stable(wday_q) && $stable(mday_q) && $stable(month_q) &&
                               $stable(year_q)));

  a_r3_minute_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[6:0] == 7'h59 && !wr_any) |=>
      (sec_q[6:0] == 7'h59 || (sec_q[6:0] == 7'h00 && min_q != $past(min_q))));

  a_r7_century_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hour_q[7] && !ld_hour) |=> (hour_q[6] == $past(hour_q[6])));

  a_r4_wday_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (wday_q != 8'h00 && !ld_wday) |=> (wday_q != 8'h00));

endmodule

bind bcd_calendar bcd_calendar_chk chk_i (.*);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0, ld_mday = 0, ld_month = 0, ld_year = 0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, month_q, year_q;

  always #2.5 clk = ~clk;

  bcd_calendar #(.DIV_COUNT(DIV)) uut (
    .clk(clk), .rst_n(rst_n),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
    .ld_mday(ld_mday), .ld_month(ld_month), .ld_year(ld_year), .ld_data(ld_data),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .wday_q(wday_q),
    .mday_q(mday_q), .month_q(month_q), .year_q(year_q)
  );

  typedef struct {
    int          due;
    logic [55:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  item_t cur;
  int cyc = 0;
  int base = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      logic [55:0] got;
      cur = sbq.pop_front();
      got = {year_q, month_q, mday_q, wday_q, hour_q, min_q, sec_q};
      n_cmp++;
      if (cur.due != cyc || got !== cur.exp) begin
        n_bad++;
        $display("FAIL %s at cycle %0d (due %0d): got %h expected %h", cur.tag, cyc, cur.due, got, cur.exp);
      end
    end
  end

  task automatic wr(input int f, input logic [7:0] d);
    @(negedge clk);
    ld_data = d;
    ld_sec = (f == 0); ld_min = (f == 1); ld_hour = (f == 2); ld_wday = (f == 3);
    ld_mday = (f == 4); ld_month = (f == 5); ld_year = (f == 6);
    @(posedge clk);
    @(negedge clk);
    {ld_sec, ld_min, ld_hour, ld_wday, ld_mday, ld_month, ld_year} = '0;
    base = cyc;
  endtask

  task automatic expect_after(input string tag, input int n,
                              input logic [7:0] s, m, h, w, d, mo, y);
    item_t it;
    it.due = base + n;
    it.exp = {y, mo, d, w, h, m, s};
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic setup(input logic [7:0] h, w, d, mo, y, m, s);
    wr(0, 8'h80);
    wr(1, m); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
    wr(0, s);
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
  endtask

  task automatic last_day(input string tag, input logic [7:0] d, mo, y,
                          input logic [7:0] ed, emo);
    setup(8'h23, 8'h03, d, mo, y, 8'h59, 8'h59);
    expect_after(tag, DIV, 8'h00, 8'h00, 8'h00, 8'h04, ed, emo, y);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base = cyc;
    expect_after("R1 reset state", 1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    drain();

    setup(8'h00, 8'h02, 8'h10, 8'h05, 8'h30, 8'h00, 8'h08);
    expect_after("R9 hold before tick", DIV - 1, 8'h08, 8'h00, 8'h00, 8'h02, 8'h10, 8'h05, 8'h30);
    expect_after("R2 first step", DIV, 8'h09, 8'h00, 8'h00, 8'h02, 8'h10, 8'h05, 8'h30);
    expect_after("R2 decimal carry", 2 * DIV, 8'h10, 8'h00, 8'h00, 8'h02, 8'h10, 8'h05, 8'h30);
    drain();

    setup(8'h23, 8'h07, 8'h15, 8'h03, 8'h21, 8'h59, 8'h58);
    expect_after("R3 midnight chain", 2 * DIV, 8'h00, 8'h00, 8'h00, 8'h01, 8'h16, 8'h03, 8'h21);
    expect_after("R4 weekday 7 to 1", 2 * DIV, 8'h00, 8'h00, 8'h00, 8'h01, 8'h16, 8'h03, 8'h21);
    drain();

    setup(8'h05, 8'h01, 8'h14, 8'h06, 8'h40, 8'h59, 8'h59);
    expect_after("R3 hour carry", DIV, 8'h00, 8'h00, 8'h06, 8'h01, 8'h14, 8'h06, 8'h40);
    drain();

    last_day("R5 april 30", 8'h30, 8'h04, 8'h21, 8'h01, 8'h05);
    last_day("R5 november 30", 8'h30, 8'h11, 8'h21, 8'h01, 8'h12);
    last_day("R5 july 30 not last", 8'h30, 8'h07, 8'h21, 8'h31, 8'h07);
    last_day("R5 july 31", 8'h31, 8'h07, 8'h21, 8'h01, 8'h08);

    last_day("R6 feb 28 year 23", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    last_day("R6 feb 28 year 24", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    last_day("R6 feb 29 year 24", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    last_day("R6 feb 28 year 00", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
    last_day("R6 feb 28 year 10", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
    last_day("R6 feb 28 year 12", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02);

    setup(8'hA3, 8'h03, 8'h31, 8'h12, 8'h99, 8'h59, 8'h59);
    expect_after("R7 century toggles 0 to 1", DIV, 8'h00, 8'h00, 8'hC0, 8'h04, 8'h01, 8'h01, 8'h00);
    drain();
    setup(8'hE3, 8'h03, 8'h31, 8'h12, 8'h99, 8'h59, 8'h59);
    expect_after("R7 century toggles 1 to 0", DIV, 8'h00, 8'h00, 8'h80, 8'h04, 8'h01, 8'h01, 8'h00);
    drain();
    setup(8'h63, 8'h03, 8'h31, 8'h12, 8'h99, 8'h59, 8'h59);
    expect_after("R7 century held when disabled", DIV, 8'h00, 8'h00, 8'h40, 8'h04, 8'h01, 8'h01, 8'h00);
    drain();
    setup(8'hA3, 8'h03, 8'h31, 8'h12, 8'h45, 8'h59, 8'h59);
    expect_after("R5 december to january", DIV, 8'h00, 8'h00, 8'h80, 8'h04, 8'h01, 8'h01, 8'h46);
    drain();

    setup(8'h10, 8'h02, 8'h05, 8'h08, 8'h50, 8'h20, 8'h85);
    expect_after("R8 halted", 3 * DIV, 8'h85, 8'h20, 8'h10, 8'h02, 8'h05, 8'h08, 8'h50);
    drain();
    wr(0, 8'h05);
    expect_after("R8 resumed", DIV, 8'h06, 8'h20, 8'h10, 8'h02, 8'h05, 8'h08, 8'h50);
    drain();

    wr(0, 8'h20);
    wr(0, 8'h30);
    expect_after("R9 reload restarts second", DIV - 1, 8'h30, 8'h20, 8'h10, 8'h02, 8'h05, 8'h08, 8'h50);
    expect_after("R9 first tick after reload", DIV, 8'h31, 8'h20, 8'h10, 8'h02, 8'h05, 8'h08, 8'h50);
    drain();

    setup(8'hC7, 8'hFD, 8'hD9, 8'hF1, 8'h88, 8'hC2, 8'h91);
    expect_after("R10 field masks", 1, 8'h91, 8'h42, 8'hC7, 8'h05, 8'h19, 8'h11, 8'h88);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule